// File: doc/BRIEF.md
# External Address-Match Copy Resolver

This block makes the copy decision for each received frame on a network adapter. Two sources feed it: a match result from the adapter's internal address comparison, and two status lines from an external address checker, one for match and one for fail. When the frame reaches its decision point, a one-cycle strobe latches the result. The outputs are a copy flag and a single flag that asks the frame path to set both the address-recognised bit and the frame-copied bit.

The external lines are asynchronous to the block, so a flop chain synchronises them first. A copy-all mode copies every frame and ignores the external checker. A presence input marks a checker that is missing or not yet initialised. While it is low the external lines have no effect. An armed status output reports that a present checker is still working on the frame.

Top module: `ext_copy_resolver`

## Requirements
- R1: While rst_ni is low, copy_o, set_ind_o and decided_o are 0.
- R2: A change on ext_match_i or ext_fail_i reaches armed_o after exactly SYNC_STAGES rising clock edges (default 2).
- R3: With checker_present_i=1 and copy_all_i=0, synchronised lines match=1 and fail=0 at the strobe give copy_o=1 and set_ind_o=1.
- R4: With synchronised fail=1 at the strobe, the external checker counts as not matched, whatever the match line shows.
- R5: With both synchronised lines at 0 at the strobe (checker still armed), the external result counts as no match.
- R6: armed_o is 1 exactly when checker_present_i=1 and both synchronised lines are 0.
- R7: int_match_i=1 at the strobe gives copy_o=1 and set_ind_o=1, whatever the external lines show.
- R8: copy_all_i=1 at the strobe gives copy_o=1. The external lines are ignored, and set_ind_o then equals int_match_i.
- R9: With checker_present_i=0, the external lines have no effect on copy_o or set_ind_o, and armed_o is 0.
- R10: decided_o is 1 for exactly the cycle after each strobe. copy_o and set_ind_o change only on the edge where decide_i is sampled high, and hold their values until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| decide_i | input | 1 | One-cycle decision-point strobe per frame |
| copy_all_i | input | 1 | Copy every frame, ignore external lines |
| checker_present_i | input | 1 | External checker driven and initialised |
| ext_match_i | input | 1 | External checker match line (async) |
| ext_fail_i | input | 1 | External checker fail line (async) |
| int_match_i | input | 1 | Internal address match for this frame |
| copy_o | output | 1 | Latched copy decision |
| set_ind_o | output | 1 | Set address-recognised and frame-copied bits |
| decided_o | output | 1 | Pulse: a new decision was latched |
| armed_o | output | 1 | Present checker is still processing |

## Verification
The hardest case to produce from the ports is a decision taken on synchronised line values that differ from the raw inputs. At the strobe edge the chain still holds older values than the pins. The stimulus sets the lines and lets SYNC_STAGES edges pass before it strobes. It also checks armed_o one edge early and one edge late, which pins the synchroniser latency. Each table row is then strobed and the held outputs are compared a cycle later, to show that nothing moves between strobes.

// File: rtl/ext_copy_pkg.sv
package ext_copy_pkg;
  typedef enum logic [1:0] {
    EXT_ABSENT = 2'd0,
    EXT_ARMED  = 2'd1,
    EXT_HIT    = 2'd2,
    EXT_MISS   = 2'd3
  } ext_stat_e;
endpackage

// File: rtl/ecr_sync.sv
module ecr_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= '0;
      else if (s == 0) chain_q[s] <= d_i;
      else chain_q[s] <= chain_q[(s > 0) ? s-1 : 0];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ecr_classify.sv
module ecr_classify
  import ext_copy_pkg::*;
(
  input  logic      present_i,
  input  logic      match_i,
  input  logic      fail_i,
  output ext_stat_e stat_o
);
  // fail outranks match
  always_comb begin
    if (!present_i)   stat_o = EXT_ABSENT;
    else if (fail_i)  stat_o = EXT_MISS;
    else if (match_i) stat_o = EXT_HIT;
    else              stat_o = EXT_ARMED;
  end
endmodule

// File: rtl/ecr_decide.sv
module ecr_decide
  import ext_copy_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      decide_i,
  input  logic      copy_all_i,
  input  logic      int_match_i,
  input  ext_stat_e stat_i,
  output logic      copy_o,
  output logic      set_ind_o,
  output logic      decided_o
);
  logic ext_hit, addr_hit;

  assign ext_hit  = (stat_i == EXT_HIT) && !copy_all_i;
  assign addr_hit = ext_hit || int_match_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      copy_o    <= 1'b0;
      set_ind_o <= 1'b0;
      decided_o <= 1'b0;
    end else begin
      decided_o <= decide_i;
      if (decide_i) begin
        copy_o    <= addr_hit || copy_all_i;
        set_ind_o <= addr_hit;
      end
    end
  end

  // R10
  strobe_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decide_i |=> decided_o);
  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !decide_i |=> ($stable(copy_o) && $stable(set_ind_o) && !decided_o));
  // R7
  int_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decide_i && int_match_i) |=> (copy_o && set_ind_o));
  // R8
  copy_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decide_i && copy_all_i) |=> (copy_o && (set_ind_o == $past(int_match_i))));
  // R4
  fail_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decide_i && stat_i == EXT_MISS && !int_match_i && !copy_all_i) |=> !copy_o);
endmodule

// File: rtl/ext_copy_resolver.sv
module ext_copy_resolver
  import ext_copy_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic decide_i,
  input  logic copy_all_i,
  input  logic checker_present_i,
  input  logic ext_match_i,
  input  logic ext_fail_i,
  input  logic int_match_i,
  output logic copy_o,
  output logic set_ind_o,
  output logic decided_o,
  output logic armed_o
);
  localparam int LINES = 2;

  logic [LINES-1:0] lines_s;
  ext_stat_e        stat;

  ecr_sync #(.STAGES(SYNC_STAGES), .WIDTH(LINES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ext_fail_i, ext_match_i}),
    .q_o   (lines_s)
  );

  ecr_classify u_class (
    .present_i(checker_present_i),
    .match_i  (lines_s[0]),
    .fail_i   (lines_s[1]),
    .stat_o   (stat)
  );

  ecr_decide u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .decide_i   (decide_i),
    .copy_all_i (copy_all_i),
    .int_match_i(int_match_i),
    .stat_i     (stat),
    .copy_o     (copy_o),
    .set_ind_o  (set_ind_o),
    .decided_o  (decided_o)
  );

  assign armed_o = (stat == EXT_ARMED);

  // R9
  absent_not_armed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !checker_present_i |-> !armed_o);
  // R9
  absent_no_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decide_i && !checker_present_i && !int_match_i && !copy_all_i) |=> (!copy_o && !set_ind_o));
endmodule

// File: tb/ext_copy_resolver_bench.sv
module ext_copy_resolver_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic decide = 0, copy_all = 0, present = 0, ematch = 0, efail = 0, imatch = 0;
  logic copy, ind, decided, armed;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ext_copy_resolver u_ext_copy_resolver (
    .clk_i(clk), .rst_ni(rst_n), .decide_i(decide), .copy_all_i(copy_all),
    .checker_present_i(present), .ext_match_i(ematch), .ext_fail_i(efail),
    .int_match_i(imatch), .copy_o(copy), .set_ind_o(ind),
    .decided_o(decided), .armed_o(armed)
  );

  // {copy_all, present, match, fail, int_match, exp_copy, exp_ind}
  localparam logic [6:0] VEC [12] = '{
    7'b0_1_1_0_0_1_1,  // R3
    7'b0_1_1_1_0_0_0,  // R4
    7'b0_1_0_1_0_0_0,  // R4
    7'b0_1_0_0_0_0_0,  // R5
    7'b0_1_0_0_1_1_1,  // R7
    7'b0_1_0_1_1_1_1,  // R7
    7'b1_1_0_0_0_1_0,  // R8
    7'b1_1_1_0_0_1_0,  // R8
    7'b1_1_0_1_1_1_1,  // R8
    7'b0_0_1_0_0_0_0,  // R9
    7'b0_0_0_0_0_0_0,  // R9
    7'b1_0_1_0_0_1_0   // R8 R9
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    step(2);
    // R1 reset state
    chk("R1 copy", copy, 1'b0);
    chk("R1 ind", ind, 1'b0);
    chk("R1 decided", decided, 1'b0);
    rst_n = 1'b1;

    // R2 latency and R6 armed
    present = 1; ematch = 0; efail = 0;
    step(3);
    chk("R6 armed idle", armed, 1'b1);
    ematch = 1;
    step(1);
    chk("R2 one edge", armed, 1'b1);
    step(1);
    chk("R2 two edges", armed, 1'b0);
    ematch = 0; efail = 1;
    step(3);
    chk("R6 fail not armed", armed, 1'b0);

    for (int i = 0; i < 12; i++) begin
      {copy_all, present, ematch, efail, imatch} = VEC[i][6:2];
      step(3);
      chk("R6/R9 armed", armed, present & ~ematch & ~efail);
      decide = 1;
      step(1);
      decide = 0;
      chk("R10 decided", decided, 1'b1);
      chk("R3/R4/R5/R7/R8/R9 copy", copy, VEC[i][1]);
      chk("R3/R4/R5/R7/R8/R9 ind", ind, VEC[i][0]);
      // flip inputs, outputs must hold
      ematch = ~ematch; imatch = ~imatch; copy_all = ~copy_all;
      step(3);
      chk("R10 pulse", decided, 1'b0);
      chk("R10 hold copy", copy, VEC[i][1]);
      chk("R10 hold ind", ind, VEC[i][0]);
    end

    // R4 fail wins, decided on synced value: raw lines change to match just before strobe
    copy_all = 0; imatch = 0; present = 1; ematch = 1; efail = 1;
    step(3);
    efail = 0;
    decide = 1;
    step(1);
    decide = 0;
    chk("R4 synced fail at strobe", copy, 1'b0);
    step(2);
    decide = 1;
    step(1);
    decide = 0;
    chk("R3 after sync", copy, 1'b1);
    chk("R3 after sync ind", ind, 1'b1);

    // R1 reset clears latched decision
    rst_n = 0;
    step(1);
    chk("R1 reset copy", copy, 1'b0);
    chk("R1 reset ind", ind, 1'b0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule